// File: doc/BRIEF.md
# Probabilistic Hybrid Batch Arbiter

This block sits between per-source batch queues and the per-bank DRAM queues of a memory controller. Each source offers at most one batch at a time, its oldest fully formed one, by raising a ready flag and presenting that batch's head request. When the arbiter is idle and at least one source is ready, it makes one decision. That decision picks a winner either by fewest outstanding requests (shortest-job-first) or by a rotating pointer (round-robin). The arbiter then drains the winner's batch toward the bank queues, one request per cycle, until the batch's last request.

The policy is chosen again at each decision. A free-running 16-bit LFSR supplies a draw, and its low byte is compared against an 8-bit software probability. A small value favours the round-robin policy, which keeps memory-intensive sources such as a GPU moving. A large value favours shortest-job-first, which keeps latency-sensitive CPU sources responsive. Per-source outstanding counters go up when a request is forwarded and go down on a completion pulse from the memory side.

Top module: `hybrid_batch_arbiter`

## Requirements
- R1: A source whose ready flag `rdy_i[s]` is low at the decision cycle is never granted.
- R2: In shortest-job-first mode (`sjf_o`=1), the grant goes to the ready source with the smallest outstanding count. On a tie, the lowest source index wins.
- R3: In round-robin mode (`sjf_o`=0), the grant goes to the first ready source at or after the rotating pointer, counting upward with wrap. After every grant in either mode, the pointer moves to the granted index plus one, wrapping to 0 after the last source. The pointer is 0 after reset.
- R4: At each decision, shortest-job-first is used exactly when the LFSR's low byte is below `prob_i` (an unsigned 8-bit value, a fraction of 256). `prob_i`=0 always gives round-robin. A mid value gives both modes over a run of decisions. 255 gives shortest-job-first on nearly every decision.
- R5: A decision is registered at the clock edge where the arbiter is idle and some source is ready. From the next cycle on, `busy_o` is high and `grant_o`/`sjf_o` hold the decision. Each cycle, `req_vld_o`, `req_data_o` and `req_last_o` carry the granted source's head request, and `pop_o` is one-hot on the granted source. `busy_o` falls after the edge that forwards the request flagged last. No other decision is made while `busy_o` is high.
- R6: Each source's outstanding count rises by one per forwarded request and falls by one per `cmpl_i` pulse, with no change when both happen in the same cycle. The count saturates at 0 and at 2^CNT_W-1.
- R7: While idle with no source ready, `busy_o` and `req_vld_o` stay low, and the round-robin pointer does not move.
- R8: During and right after reset, `busy_o`, `req_vld_o` and `pop_o` are zero, and all outstanding counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prob_i | input | 8 | Shortest-job-first probability, in 1/256 steps |
| rdy_i | input | N_SRC | Per-source flag: oldest batch complete and ready |
| src_data_i | input | N_SRC*DATA_W | Per-source head request payload, source s at bits s*DATA_W |
| src_last_i | input | N_SRC | Per-source flag: head request ends its batch |
| cmpl_i | input | N_SRC | Per-source completion pulse |
| pop_o | output | N_SRC | Head request of this source was taken this cycle |
| busy_o | output | 1 | A granted batch is being drained; grant is valid |
| grant_o | output | $clog2(N_SRC) | Index of the granted source |
| sjf_o | output | 1 | Mode of the current grant: 1 shortest-job-first, 0 round-robin |
| req_vld_o | output | 1 | Forwarded request valid |
| req_data_o | output | DATA_W | Forwarded request payload |
| req_last_o | output | 1 | Forwarded request ends the batch |

## Verification
The bench builds the arbiter with four sources, 8-bit payloads and CNT_W=3. With a ceiling of 7, a single nine-request batch drives a counter into its upper saturation, where a wrapping counter would read 1 instead. The bench then checks that shortest-job-first prefers a source holding 3 outstanding requests. Completions sent to an idle source exercise the floor at zero, and with only four sources the pointer wraps within a few grants.

// File: rtl/hba_pkg.sv
package hba_pkg;
  localparam int LFSR_W = 16;
  localparam int DRAW_W = 8;

  typedef enum logic {
    MODE_RR  = 1'b0,
    MODE_SJF = 1'b1
  } mode_e;
endpackage

// File: rtl/hba_lfsr.sv
module hba_lfsr
  import hba_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DRAW_W-1:0] draw_o
);
  logic [LFSR_W-1:0] state_q;
  logic              fb;

  // x^16 + x^14 + x^13 + x^11 + 1, maximal length
  assign fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {state_q[LFSR_W-2:0], fb};
  end

  assign draw_o = state_q[DRAW_W-1:0];

  // R4
  lfsr_alive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/hba_out_cnt.sv
module hba_out_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;

  // R6
  cnt_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && cnt_q == '0) |=> cnt_q == '0);
  // R6
  cnt_ceil_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R6
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/hba_sjf_pick.sv
module hba_sjf_pick #(
  parameter int N_SRC = 4,
  parameter int CNT_W = 6,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]       rdy_i,
  input  logic [N_SRC*CNT_W-1:0] cnt_i,
  output logic [IDX_W-1:0]       idx_o
);
  logic [CNT_W-1:0] best_cnt;
  logic             found;

  // strict compare keeps the lowest index on ties
  always_comb begin
    idx_o    = '0;
    best_cnt = '1;
    found    = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (rdy_i[i] && (!found || cnt_i[i*CNT_W +: CNT_W] < best_cnt)) begin
        idx_o    = IDX_W'(i);
        best_cnt = cnt_i[i*CNT_W +: CNT_W];
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hba_rr_pick.sv
module hba_rr_pick #(
  parameter int N_SRC = 4,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] rdy_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [IDX_W-1:0] idx_o
);
  logic found;

  always_comb begin
    idx_o = '0;
    found = 1'b0;
    for (int k = 0; k < N_SRC; k++) begin
      int j;
      j = int'(ptr_i) + k;
      if (j >= N_SRC) j = j - N_SRC;
      if (!found && rdy_i[j]) begin
        idx_o = IDX_W'(j);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hybrid_batch_arbiter.sv
module hybrid_batch_arbiter
  import hba_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int CNT_W  = 6,
  parameter int DATA_W = 32,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [7:0]                 prob_i,
  input  logic [N_SRC-1:0]           rdy_i,
  input  logic [N_SRC*DATA_W-1:0]    src_data_i,
  input  logic [N_SRC-1:0]           src_last_i,
  input  logic [N_SRC-1:0]           cmpl_i,
  output logic [N_SRC-1:0]           pop_o,
  output logic                       busy_o,
  output logic [$clog2(N_SRC)-1:0]   grant_o,
  output logic                       sjf_o,
  output logic                       req_vld_o,
  output logic [DATA_W-1:0]          req_data_o,
  output logic                       req_last_o
);
  localparam int IDX_W = $clog2(N_SRC);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SRC - 1);

  logic [N_SRC*CNT_W-1:0] cnt_flat;
  logic [DRAW_W-1:0]      draw;
  logic [IDX_W-1:0]       sjf_idx, rr_idx, win_idx, rr_ptr_q, grant_q;
  logic                   busy_q, decide, use_sjf, drain_end;
  mode_e                  mode_q;

  hba_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .draw_o (draw)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_cnt
    hba_out_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (pop_o[s]),
      .dec_i  (cmpl_i[s]),
      .cnt_o  (cnt_flat[s*CNT_W +: CNT_W])
    );
  end

  hba_sjf_pick #(.N_SRC(N_SRC), .CNT_W(CNT_W)) u_sjf (
    .rdy_i (rdy_i),
    .cnt_i (cnt_flat),
    .idx_o (sjf_idx)
  );

  hba_rr_pick #(.N_SRC(N_SRC)) u_rr (
    .rdy_i (rdy_i),
    .ptr_i (rr_ptr_q),
    .idx_o (rr_idx)
  );

  assign decide    = !busy_q && (|rdy_i);
  assign use_sjf   = draw < prob_i;
  assign win_idx   = use_sjf ? sjf_idx : rr_idx;
  assign drain_end = busy_q && src_last_i[grant_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      grant_q  <= '0;
      mode_q   <= MODE_RR;
      rr_ptr_q <= '0;
    end else if (decide) begin
      busy_q   <= 1'b1;
      grant_q  <= win_idx;
      mode_q   <= use_sjf ? MODE_SJF : MODE_RR;
      rr_ptr_q <= (win_idx == LAST_IDX) ? '0 : win_idx + 1'b1;
    end else if (drain_end) begin
      busy_q   <= 1'b0;
    end
  end

  always_comb begin
    pop_o = '0;
    if (busy_q) pop_o[grant_q] = 1'b1;
  end

  assign busy_o     = busy_q;
  assign grant_o    = grant_q;
  assign sjf_o      = (mode_q == MODE_SJF);
  assign req_vld_o  = busy_q;
  assign req_data_o = src_data_i[grant_q*DATA_W +: DATA_W];
  assign req_last_o = busy_q && src_last_i[grant_q];

  // R1
  grant_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decide |=> rdy_i[$past(rdy_i) == rdy_i ? grant_q : grant_q] || $past(rdy_i[win_idx]));
  // R3
  rr_ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decide |=> rr_ptr_q == ((grant_q == LAST_IDX) ? '0 : grant_q + 1'b1));
  // R4
  prob_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide && prob_i == 8'd0) |=> !sjf_o);
  // R5
  pop_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_o) && (busy_o == (|pop_o)));
  // R5
  hold_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !src_last_i[grant_q]) |=> busy_q && $stable(grant_q) && $stable(mode_q));
  // R5
  drain_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_end |=> !busy_q);
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !(|rdy_i)) |=> !busy_q && $stable(rr_ptr_q));
endmodule

// File: tb/tb_hybrid_batch_arbiter.sv
`timescale 1ns/1ps
module tb_hybrid_batch_arbiter;
  localparam int N      = 4;
  localparam int CW     = 3;
  localparam int DW     = 8;
  localparam int CMAX   = (1 << CW) - 1;
  localparam int MEMD   = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    prob_i = 8'd0;
  logic [N-1:0]  rdy_i = '0;
  logic [N*DW-1:0] src_data_i = '0;
  logic [N-1:0]  src_last_i = '0;
  logic [N-1:0]  cmpl_i = '0;
  logic [N-1:0]  pop_o;
  logic          busy_o;
  logic [1:0]    grant_o;
  logic          sjf_o;
  logic          req_vld_o;
  logic [DW-1:0] req_data_o;
  logic          req_last_o;

  always #2.5 clk = ~clk;

  hybrid_batch_arbiter #(.N_SRC(N), .CNT_W(CW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .prob_i(prob_i), .rdy_i(rdy_i),
    .src_data_i(src_data_i), .src_last_i(src_last_i), .cmpl_i(cmpl_i),
    .pop_o(pop_o), .busy_o(busy_o), .grant_o(grant_o), .sjf_o(sjf_o),
    .req_vld_o(req_vld_o), .req_data_o(req_data_o), .req_last_o(req_last_o)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // source model
  logic [DW-1:0] mem_d [N][MEMD];
  logic          mem_l [N][MEMD];
  int wr[N], hd[N], nb[N];
  int seq = 1;
  logic [N-1:0] cmpl_req = '0;
  logic [N-1:0] pop_rec = '0;

  // reference state
  int cnt_m[N];
  int rr_m = 0;
  bit pred_v = 0;
  int pred_sjf, pred_rr;
  logic [N-1:0] pred_rdy;
  bit busy_prev = 0;
  int last_grant = -1;
  int sjf_seen = 0, rr_seen = 0;
  logic [DW:0] sb[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic add_batch(input int s, input int len);
    for (int i = 0; i < len; i++) begin
      mem_d[s][wr[s]] = DW'(seq);
      mem_l[s][wr[s]] = (i == len - 1);
      seq++;
      wr[s]++;
    end
    nb[s]++;
  endtask

  // driver side of the scoreboard: expected items of the granted batch
  task automatic push_batch(input int s);
    int p;
    p = hd[s];
    while (1) begin
      sb.push_back({mem_l[s][p], mem_d[s][p]});
      if (mem_l[s][p]) break;
      p++;
    end
  endtask

  initial begin
    for (int s = 0; s < N; s++) begin
      wr[s] = 0; hd[s] = 0; nb[s] = 0; cnt_m[s] = 0;
    end
    // R8
    #1;
    chk(busy_o == 0 && req_vld_o == 0 && pop_o == '0, "R8 in reset", int'(busy_o), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    forever begin
      @(negedge clk);
      for (int s = 0; s < N; s++)
        if (pop_rec[s]) begin
          if (mem_l[s][hd[s]]) nb[s]--;
          hd[s]++;
        end
      for (int s = 0; s < N; s++) begin
        rdy_i[s] = nb[s] > 0;
        src_data_i[s*DW +: DW] = mem_d[s][hd[s] % MEMD];
        src_last_i[s] = mem_l[s][hd[s] % MEMD];
      end
      cmpl_i = cmpl_req;
      cmpl_req = '0;
      #1;
      pop_rec = pop_o;
      // R5 latency: a decision seen last cycle must show as busy now
      if (pred_v) begin
        chk(busy_o && !busy_prev, "R5 grant latency", int'(busy_o), 1);
        if (busy_o) begin
          chk(pred_rdy[grant_o], "R1 ready source", int'(grant_o), pred_sjf);
          if (sjf_o) begin
            sjf_seen++;
            chk(int'(grant_o) == pred_sjf, "R2 fewest outstanding", int'(grant_o), pred_sjf);
          end else begin
            rr_seen++;
            chk(int'(grant_o) == pred_rr, "R3 rotation", int'(grant_o), pred_rr);
          end
          if (prob_i == 8'd0) chk(!sjf_o, "R4 p zero", int'(sjf_o), 0);
          last_grant = int'(grant_o);
          rr_m = (int'(grant_o) + 1) % N;
          push_batch(int'(grant_o));
        end
      end else if (!busy_prev) begin
        // R7
        chk(!busy_o && !req_vld_o, "R7 idle", int'(busy_o), 0);
      end
      // monitor
      if (req_vld_o) begin
        logic [DW:0] e;
        if (sb.size() == 0) chk(0, "R5 unexpected forward", int'(req_data_o), -1);
        else begin
          e = sb.pop_front();
          chk(req_data_o == e[DW-1:0] && req_last_o == e[DW], "R5 forwarded item",
              int'({req_last_o, req_data_o}), int'(e));
          chk(pop_o == (N'(1) << grant_o), "R5 pop onehot", int'(pop_o), 1 << grant_o);
        end
      end
      // prediction for a decision at the coming edge
      pred_v = !busy_o && (|rdy_i);
      pred_rdy = rdy_i;
      pred_sjf = -1;
      pred_rr = -1;
      for (int s = 0; s < N; s++)
        if (rdy_i[s] && (pred_sjf < 0 || cnt_m[s] < cnt_m[pred_sjf])) pred_sjf = s;
      for (int k = 0; k < N; k++)
        if (pred_rr < 0 && rdy_i[(rr_m + k) % N]) pred_rr = (rr_m + k) % N;
      // counter reference, R6
      for (int s = 0; s < N; s++) begin
        int d;
        d = ((req_vld_o && int'(grant_o) == s) ? 1 : 0) - (cmpl_i[s] ? 1 : 0);
        cnt_m[s] = cnt_m[s] + d;
        if (cnt_m[s] < 0) cnt_m[s] = 0;
        if (cnt_m[s] > CMAX) cnt_m[s] = CMAX;
      end
      busy_prev = busy_o;
    end
  end

  task automatic wait_drain();
    int guard;
    guard = 0;
    do begin
      @(posedge clk); #1;
      guard++;
    end while ((busy_o || (nb[0] + nb[1] + nb[2] + nb[3]) > 0 || sb.size() > 0) && guard < 2000);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic zero_counts();
    for (int i = 0; i < CMAX + 2; i++) begin
      cmpl_req = '1;
      @(posedge clk); #1;
    end
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    wait (rst_n);
    @(posedge clk); #1;
    // R8
    chk(busy_o == 0 && req_vld_o == 0 && pop_o == '0, "R8 after reset", int'(busy_o), 0);
    // R7: idle with nothing ready
    repeat (6) @(posedge clk);
    #1;
    // R3: rotation from pointer 0
    prob_i = 8'd0;
    for (int s = 0; s < N; s++) add_batch(s, 2);
    wait_drain();
    chk(last_grant == 3, "R3 full rotation end", last_grant, 3);
    add_batch(1, 1); add_batch(3, 3);
    wait_drain();
    chk(last_grant == 3, "R3 skip unready", last_grant, 3);
    repeat (5) @(posedge clk);
    #1;
    add_batch(0, 1); add_batch(2, 2);
    wait_drain();
    chk(last_grant == 2, "R3 wrap and R7 pointer held", last_grant, 2);
    // R6 upper saturation
    zero_counts();
    add_batch(0, 9);
    wait_drain();
    add_batch(1, 3);
    wait_drain();
    prob_i = 8'd255;
    add_batch(0, 1); add_batch(1, 1);
    @(posedge clk); #1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk(last_grant == 1, "R6 ceiling picks lighter source", last_grant, 1);
    wait_drain();
    // R6 floor
    zero_counts();
    add_batch(3, 2);
    wait_drain();
    cmpl_req = 4'b0100; @(posedge clk); #1;
    cmpl_req = 4'b0100; @(posedge clk); #1;
    repeat (2) @(posedge clk);
    #1;
    add_batch(2, 1); add_batch(3, 1);
    @(posedge clk); #1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk(last_grant == 2, "R6 floor at zero", last_grant, 2);
    wait_drain();
    // R2 tie
    zero_counts();
    add_batch(3, 1); add_batch(2, 1); add_batch(1, 1);
    @(posedge clk); #1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk(last_grant == 1, "R2 tie lowest index", last_grant, 1);
    wait_drain();
    chk(sjf_seen > 0, "R4 p=255 uses fewest-outstanding", sjf_seen, 1);
    // R4 mixed
    prob_i = 8'd128;
    sjf_seen = 0; rr_seen = 0;
    for (int i = 0; i < 40; i++) begin
      add_batch(i % N, 1 + (i % 3));
      add_batch((i * 3 + 1) % N, 1);
      if (i % 4 == 0) cmpl_req = 4'b1010;
      wait_drain();
    end
    chk(sjf_seen > 0 && rr_seen > 0, "R4 both modes at p=128", sjf_seen, rr_seen);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    finish_run();
  end
endmodule